// File: doc/BRIEF.md
# Two-State Device Power Manager

This block keeps the device power state of a host-controller function that has only two power states: fully on and off. A configuration write port loads a 2-bit state field. Only the encodings for the on state (00b) and the off state (11b) are stored. Any other value is dropped without a response or side effect. When the field goes from off back to on, the block raises a one-cycle internal reset for the function.

The current state gates the rest of the function. In the off state, memory-mapped register requests are answered with an abort and are not forwarded. The interrupt output is forced low, and the debug-port enable is withdrawn. The block also collects per-port wake conditions and their enable bits. It raises a power-management-event request only while the function is off. All gated outputs are registered and respond one clock after their inputs.

Top module: `dev_pwr_mgr`

## Requirements
- R1: In the cycle after synchronous reset, `pstate` is 00b, `dbg_en` is 1, and `fn_rst`, `mmio_fwd`, `mmio_abort`, `irq_out` and `pme_req` are 0.
- R2: A write (`cfg_wr_en`=1) of 00b (on) or 11b (off) is stored and appears on `pstate` in the cycle after the write.
- R3: A write of 01b or 10b leaves `pstate` unchanged and produces no `fn_rst` pulse.
- R4: A write of 00b while `pstate` is 11b drives `fn_rst` high for exactly one cycle, in the cycle after the write.
- R5: A write of 00b while in 00b, or of 11b while in 11b, produces no `fn_rst` pulse and leaves `pstate` unchanged.
- R6: An `mmio_req` sampled while `pstate` is 11b gives `mmio_abort`=1 and `mmio_fwd`=0 in the next cycle.
- R7: An `mmio_req` sampled while `pstate` is 00b gives `mmio_fwd`=1 and `mmio_abort`=0 in the next cycle. With no request, both are 0.
- R8: `irq_out` equals `irq_src` AND (`pstate`==00b), both taken one cycle earlier. It is never 1 in a cycle that follows a cycle with `pstate`==11b.
- R9: `dbg_en` is 1 exactly when `pstate` was 00b in the previous cycle.
- R10: `pme_req` is 1 exactly when, in the previous cycle, `pstate` was 11b and some bit i had both `port_wake[i]` and `wake_en[i]` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the power-state field |
| cfg_wr_data | input | 2 | Value written to the power-state field |
| pstate | output | 2 | Current power-state field (00b on, 11b off) |
| fn_rst | output | 1 | One-cycle internal reset on leaving the off state |
| mmio_req | input | 1 | Memory-mapped register request |
| mmio_fwd | output | 1 | Request passed on to the register file |
| mmio_abort | output | 1 | Request terminated with an abort |
| irq_src | input | 1 | Raw internal interrupt |
| irq_out | output | 1 | Gated interrupt |
| dbg_en | output | 1 | Debug-port enable |
| port_wake | input | N_PORTS | Per-port wake condition |
| wake_en | input | N_PORTS | Per-port wake enable |
| pme_req | output | 1 | Power-management-event request |

## Verification
The state field and `fn_rst` change one clock edge after the write that causes them. The gated outputs (`mmio_fwd`, `mmio_abort`, `irq_out`, `dbg_en`, `pme_req`) are also due one edge after their inputs. They are computed from the state held before that edge, so a state change reaches them only one cycle later again. The bench drives inputs at the falling edge and updates its model at the rising edge from the old model state. It compares every output at the next falling edge, so each result is sampled in the exact cycle it is due. Directed sequences cover each write encoding in each state, and seeded random traffic follows them.

// File: rtl/pwr_mgr_pkg.sv
package pwr_mgr_pkg;
  localparam int FIELD_W = 2;
  localparam logic [FIELD_W-1:0] PS_ON  = 2'b00;
  localparam logic [FIELD_W-1:0] PS_OFF = 2'b11;

  function automatic logic ps_legal(input logic [FIELD_W-1:0] v);
    return (v == PS_ON) || (v == PS_OFF);
  endfunction
endpackage

// File: rtl/pwr_state_reg.sv
module pwr_state_reg
  import pwr_mgr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_data,
  output logic [FIELD_W-1:0] state,
  output logic               fn_rst
);
  logic accept;
  logic wake_edge;

  always_comb begin
    accept    = wr_en && ps_legal(wr_data);
    wake_edge = accept && (state == PS_OFF) && (wr_data == PS_ON);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= PS_ON;
      fn_rst <= 1'b0;
    end else begin
      if (accept) state <= wr_data;
      fn_rst <= wake_edge;
    end
  end
endmodule

// File: rtl/pwr_gate.sv
module pwr_gate
  import pwr_mgr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [FIELD_W-1:0] state,
  input  logic               mmio_req,
  input  logic               irq_src,
  output logic               mmio_fwd,
  output logic               mmio_abort,
  output logic               irq_out,
  output logic               dbg_en
);
  logic is_on;
  assign is_on = (state == PS_ON);

  always_ff @(posedge clk) begin
    if (rst) begin
      mmio_fwd   <= 1'b0;
      mmio_abort <= 1'b0;
      irq_out    <= 1'b0;
      dbg_en     <= 1'b1;
    end else begin
      mmio_fwd   <= mmio_req && is_on;
      mmio_abort <= mmio_req && !is_on;
      irq_out    <= irq_src && is_on;
      dbg_en     <= is_on;
    end
  end
endmodule

// File: rtl/pwr_wake.sv
module pwr_wake
  import pwr_mgr_pkg::*;
#(
  parameter int N_PORTS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FIELD_W-1:0] state,
  input  logic [N_PORTS-1:0] port_wake,
  input  logic [N_PORTS-1:0] wake_en,
  output logic               pme_req
);
  logic [N_PORTS-1:0] qual;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_port
    assign qual[i] = port_wake[i] & wake_en[i];
  end

  always_ff @(posedge clk) begin
    if (rst) pme_req <= 1'b0;
    else     pme_req <= (state == PS_OFF) && (|qual);
  end
endmodule

// File: rtl/dev_pwr_mgr.sv
module dev_pwr_mgr
  import pwr_mgr_pkg::*;
#(
  parameter int N_PORTS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr_en,
  input  logic [1:0]         cfg_wr_data,
  output logic [1:0]         pstate,
  output logic               fn_rst,
  input  logic               mmio_req,
  output logic               mmio_fwd,
  output logic               mmio_abort,
  input  logic               irq_src,
  output logic               irq_out,
  output logic               dbg_en,
  input  logic [N_PORTS-1:0] port_wake,
  input  logic [N_PORTS-1:0] wake_en,
  output logic               pme_req
);
  logic [FIELD_W-1:0] cur_state;

  pwr_state_reg u_state (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_wr_en),
    .wr_data(cfg_wr_data),
    .state  (cur_state),
    .fn_rst (fn_rst)
  );

  pwr_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .state     (cur_state),
    .mmio_req  (mmio_req),
    .irq_src   (irq_src),
    .mmio_fwd  (mmio_fwd),
    .mmio_abort(mmio_abort),
    .irq_out   (irq_out),
    .dbg_en    (dbg_en)
  );

  pwr_wake #(.N_PORTS(N_PORTS)) u_wake (
    .clk      (clk),
    .rst      (rst),
    .state    (cur_state),
    .port_wake(port_wake),
    .wake_en  (wake_en),
    .pme_req  (pme_req)
  );

  assign pstate = cur_state;
endmodule

// File: rtl/dev_pwr_mgr_chk.sv
module dev_pwr_mgr_chk #(
  parameter int N_PORTS = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_wr_en,
  input logic [1:0]         cfg_wr_data,
  input logic [1:0]         pstate,
  input logic               fn_rst,
  input logic               mmio_req,
  input logic               mmio_fwd,
  input logic               mmio_abort,
  input logic               irq_out,
  input logic               dbg_en,
  input logic [N_PORTS-1:0] port_wake,
  input logic [N_PORTS-1:0] wake_en,
  input logic               pme_req
);
  p_field_legal_r2: assert property (@(posedge clk) disable iff (rst)
    (pstate == 2'b00) || (pstate == 2'b11));

  p_bad_write_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_wr_en && (cfg_wr_data == 2'b01 || cfg_wr_data == 2'b10) |=> $stable(pstate) && !fn_rst);

  p_wake_reset_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_wr_en && cfg_wr_data == 2'b00 && pstate == 2'b11 |=> fn_rst && pstate == 2'b00);

  p_reset_single_r4: assert property (@(posedge clk) disable iff (rst)
    fn_rst |=> !fn_rst);

  p_reset_cause_r5: assert property (@(posedge clk) disable iff (rst)
    fn_rst |-> $past(pstate) == 2'b11 && pstate == 2'b00);

  p_abort_off_r6: assert property (@(posedge clk) disable iff (rst)
    mmio_req && pstate == 2'b11 |=> mmio_abort && !mmio_fwd);

  p_fwd_on_r7: assert property (@(posedge clk) disable iff (rst)
    mmio_req && pstate == 2'b00 |=> mmio_fwd && !mmio_abort);

  p_irq_mask_r8: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(pstate) == 2'b00);

  p_dbg_follow_r9: assert property (@(posedge clk) disable iff (rst)
    dbg_en == ($past(pstate) == 2'b00));

  p_pme_off_r10: assert property (@(posedge clk) disable iff (rst)
    pme_req |-> $past(pstate) == 2'b11 && $past(|(port_wake & wake_en)));
endmodule

bind dev_pwr_mgr dev_pwr_mgr_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_wr_en  (cfg_wr_en),
  .cfg_wr_data(cfg_wr_data),
  .pstate     (pstate),
  .fn_rst     (fn_rst),
  .mmio_req   (mmio_req),
  .mmio_fwd   (mmio_fwd),
  .mmio_abort (mmio_abort),
  .irq_out    (irq_out),
  .dbg_en     (dbg_en),
  .port_wake  (port_wake),
  .wake_en    (wake_en),
  .pme_req    (pme_req)
);

// File: tb/dev_pwr_mgr_bench.sv
module dev_pwr_mgr_bench;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_wr_en;
  logic [1:0]    cfg_wr_data;
  logic [1:0]    pstate;
  logic          fn_rst;
  logic          mmio_req;
  logic          mmio_fwd;
  logic          mmio_abort;
  logic          irq_src;
  logic          irq_out;
  logic          dbg_en;
  logic [NP-1:0] port_wake;
  logic [NP-1:0] wake_en;
  logic          pme_req;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  logic [1:0] m_state;
  logic m_rst, m_fwd, m_abort, m_irq, m_dbg, m_pme;

  always #2.5 clk = ~clk;

  dev_pwr_mgr #(.N_PORTS(NP)) u_dev_pwr_mgr (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .pstate(pstate), .fn_rst(fn_rst), .mmio_req(mmio_req), .mmio_fwd(mmio_fwd),
    .mmio_abort(mmio_abort), .irq_src(irq_src), .irq_out(irq_out), .dbg_en(dbg_en),
    .port_wake(port_wake), .wake_en(wake_en), .pme_req(pme_req)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at time %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic legal(input logic [1:0] v);
    return (v == 2'b00) || (v == 2'b11);
  endfunction

  task automatic compare_all();
    chk(pstate,     m_state, "R2/R3 pstate");
    chk(fn_rst,     m_rst,   "R4/R5 fn_rst");
    chk(mmio_fwd,   m_fwd,   "R7 mmio_fwd");
    chk(mmio_abort, m_abort, "R6 mmio_abort");
    chk(irq_out,    m_irq,   "R8 irq_out");
    chk(dbg_en,     m_dbg,   "R9 dbg_en");
    chk(pme_req,    m_pme,   "R10 pme_req");
  endtask

  task automatic step(input logic wr, input logic [1:0] d, input logic req,
                      input logic irq, input logic [NP-1:0] wk, input logic [NP-1:0] en);
    cfg_wr_en = wr; cfg_wr_data = d; mmio_req = req; irq_src = irq;
    port_wake = wk; wake_en = en;
    @(posedge clk);
    m_rst   = wr && legal(d) && (m_state == 2'b11) && (d == 2'b00);
    m_fwd   = req && (m_state == 2'b00);
    m_abort = req && (m_state == 2'b11);
    m_irq   = irq && (m_state == 2'b00);
    m_dbg   = (m_state == 2'b00);
    m_pme   = (m_state == 2'b11) && (|(wk & en));
    if (wr && legal(d)) m_state = d;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h0000_c0de));
    rst = 1'b1; cfg_wr_en = 0; cfg_wr_data = 0; mmio_req = 0; irq_src = 0;
    port_wake = 0; wake_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    m_state = 2'b00; m_rst = 0; m_fwd = 0; m_abort = 0; m_irq = 0; m_dbg = 1; m_pme = 0;
    chk(pstate, 2'b00, "R1 pstate after reset");
    chk(dbg_en, 1'b1,  "R1 dbg_en after reset");
    chk({fn_rst, mmio_fwd, mmio_abort, irq_out, pme_req}, 0, "R1 outputs low after reset");

    // R7, R8, R10 in on state: forward, irq passes, no pme
    step(0, 2'b00, 1, 1, 4'b1111, 4'b1111);
    // R5: same-state write of on
    step(1, 2'b00, 0, 0, 0, 0);
    chk(fn_rst, 1'b0, "R5 no pulse on D0 rewrite");
    // R2: go off
    step(1, 2'b11, 1, 1, 0, 0);
    chk(pstate, 2'b11, "R2 off stored");
    // R6, R8, R9 in off state
    step(0, 2'b00, 1, 1, 4'b0010, 4'b0010);
    chk(mmio_abort, 1'b1, "R6 abort in off");
    chk(irq_out, 1'b0, "R8 irq masked in off");
    chk(pme_req, 1'b1, "R10 pme on enabled wake");
    // R10: wake without matching enable
    step(0, 2'b00, 0, 0, 4'b0100, 4'b1011);
    chk(pme_req, 1'b0, "R10 no pme without enable");
    // R3: illegal writes ignored
    step(1, 2'b01, 0, 0, 0, 0);
    chk(pstate, 2'b11, "R3 01b ignored");
    step(1, 2'b10, 0, 0, 0, 0);
    chk(fn_rst, 1'b0, "R3 10b no pulse");
    // R5: off rewrite
    step(1, 2'b11, 0, 0, 0, 0);
    chk(fn_rst, 1'b0, "R5 no pulse on D3 rewrite");
    // R4: leave off -> one-cycle pulse
    step(1, 2'b00, 0, 1, 0, 0);
    chk(fn_rst, 1'b1, "R4 pulse after wake write");
    step(0, 2'b00, 0, 1, 0, 0);
    chk(fn_rst, 1'b0, "R4 pulse lasts one cycle");
    chk(irq_out, 1'b1, "R8 irq passes after return to on");

    for (int i = 0; i < 2000; i++) begin
      logic [1:0] d;
      d = 2'($urandom_range(0, 3));
      step(($urandom_range(0, 3) == 0), d, 1'($urandom), 1'($urandom),
           NP'($urandom), NP'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule